// File: doc/BRIEF.md
# Rotating Four-Digit Date Ticker

The block shows a four-digit date on four seven-segment displays and moves the digits one display position each time a manual step switch is pressed. The digits are not stored as four separate codes. They are held in four bit-plane rings. Ring k holds bit weight k of every displayed digit. Stage j of every ring belongs to display j.

A step rotates all four rings together. Whole digits therefore move from one display to the next. The digit on the last display wraps round to the first display. After four steps the rings hold their starting contents again.

The starting date is a 16-bit BCD parameter in month-day order. The month's tens digit goes to display 0. When the block is elaborated, the initial value of each bit plane is derived from this parameter. A synchronous active-low reset loads those values. The switch input is synchronised to the clock. Its rising edge is turned into a single-cycle step pulse. Each display has its own decoder, which drives active-low segments.

Top module: `digit_ticker`

## Requirements
- R1: While reset is low at a clock edge, the four displays are loaded with the digits of DATE_BCD. Bits [15:12] go to display 0, [11:8] to display 1, [7:4] to display 2 and [3:0] to display 3. With the default 16'h0323 the displays read 0,3,2,3.
- R2: Each segment output is 7 bits, active low, with bit 6 = g down to bit 0 = a. Codes 0 to 9 show decimal digits and codes 10 to 15 show A, b, C, d, E, F. A lit segment is 0.
- R3: After one step, display j shows the digit that display j-1 showed before the step, and display 0 shows the digit that display 3 showed.
- R4: After four steps, all four displays again show their reset digits.
- R5: The displays change on the third rising clock edge after the clock edge that first samples the switch high, and not on any earlier edge.
- R6: Holding the switch high for any number of cycles produces exactly one step, and the switch falling produces none.
- R7: With no rising edge on the switch, the displays keep their contents for any number of cycles.
- R8: A reset in the middle of a rotation reloads the date pattern at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the date pattern |
| step_sw | input | 1 | Manual step switch, asynchronous to clk |
| seg_disp0 | output | 7 | Display 0 segments, active low, gfedcba |
| seg_disp1 | output | 7 | Display 1 segments, active low, gfedcba |
| seg_disp2 | output | 7 | Display 2 segments, active low, gfedcba |
| seg_disp3 | output | 7 | Display 3 segments, active low, gfedcba |

## Verification
The default date 0,3,2,3 is rotated one step at a time, and every display is compared with a model after each step. The repeated digit 3 means a rotation in the wrong direction gives a visibly different pattern from the correct one. Four further instances with other dates bring every code from 0 to F onto some display, so the decoder table is covered in full. The switch is held high for many cycles and then released, which separates edge detection from level sensing. A reset issued after one step separates a true reload from plain continued rotation.

// File: rtl/ticker_pkg.sv
// Shared widths and types for the date ticker.
// Assumes BCD-style 4-bit digit codes and 7-segment displays.
package ticker_pkg;
    localparam int DIGIT_W  = 4;
    localparam int NUM_DISP = 4;
    localparam int SEG_W    = 7;
    localparam int DATE_W   = DIGIT_W * NUM_DISP;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/step_edge.sv
// Synchronises the manual step switch and emits a one-cycle pulse on its
// rising edge. Assumes the switch is already debounced. Latency from the
// first sampling edge to the pulse is SYNC_STAGES-1 cycles.
module step_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_in,
    output logic pulse
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;

    // Sample chain: synchroniser stages followed by one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAST-1:0], sw_in};
    end

    assign pulse = sh[LAST-1] & ~sh[LAST];

    // R6: a held switch never yields two back-to-back pulses
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/plane_ring.sv
// One bit-plane ring: stage j holds this bit weight of display j's digit.
// On advance, stage j takes stage j-1 and stage 0 takes the last stage.
// Assumes INIT is fixed at elaboration; reset is synchronous, active low.
module plane_ring #(
    parameter int          STAGES = 4,
    parameter logic [STAGES-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [STAGES-1:0] q
);
    // Ring update: reload on reset, rotate toward higher stages on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= INIT;
        else if (adv) q <= {q[STAGES-2:0], q[STAGES-1]};
    end

    // R7: contents held when no advance
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));
    // R8: reset reloads the initial plane
    p_reload_r8: assert property (@(posedge clk)
        !rst_n |=> (q == INIT));
endmodule

// File: rtl/seg_decoder.sv
// Converts a 4-bit code to active-low segments ordered gfedcba.
// Covers 0-9 and A-F; purely combinational.
module seg_decoder
    import ticker_pkg::*;
(
    input  digit_t code,
    output seg_t   seg_n
);
    seg_t lit;

    // Lookup of lit segments (1 = on) for each code.
    always_comb begin
        case (code)
            4'h0: lit = 7'b0111111;
            4'h1: lit = 7'b0000110;
            4'h2: lit = 7'b1011011;
            4'h3: lit = 7'b1001111;
            4'h4: lit = 7'b1100110;
            4'h5: lit = 7'b1101101;
            4'h6: lit = 7'b1111101;
            4'h7: lit = 7'b0000111;
            4'h8: lit = 7'b1111111;
            4'h9: lit = 7'b1101111;
            4'hA: lit = 7'b1110111;
            4'hB: lit = 7'b1111100;
            4'hC: lit = 7'b0111001;
            4'hD: lit = 7'b1011110;
            4'hE: lit = 7'b1111001;
            default: lit = 7'b1110001;
        endcase
    end

    assign seg_n = ~lit;
endmodule

// File: rtl/digit_ticker.sv
// Four-display rotating date ticker. Digits are stored transposed in
// DIGIT_W bit-plane rings; one step moves each digit up one display.
// Assumes DATE_BCD lists display 0's digit in its top nibble.
module digit_ticker
    import ticker_pkg::*;
#(
    parameter logic [DATE_W-1:0] DATE_BCD    = 16'h0323,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_sw,
    output logic [6:0] seg_disp0,
    output logic [6:0] seg_disp1,
    output logic [6:0] seg_disp2,
    output logic [6:0] seg_disp3
);
    // Bit plane k initial value: bit j = bit k of display j's date digit.
    function automatic logic [NUM_DISP-1:0] plane_init(input int k);
        logic [NUM_DISP-1:0] v;
        for (int j = 0; j < NUM_DISP; j++)
            v[j] = DATE_BCD[(NUM_DISP-1-j)*DIGIT_W + k];
        return v;
    endfunction

    logic                step_pulse;
    logic [NUM_DISP-1:0] plane [DIGIT_W];
    digit_t              digit [NUM_DISP];
    seg_t                seg   [NUM_DISP];

    step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_in (step_sw),
        .pulse (step_pulse)
    );

    for (genvar k = 0; k < DIGIT_W; k++) begin : g_plane
        plane_ring #(.STAGES(NUM_DISP), .INIT(plane_init(k))) u_ring (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (step_pulse),
            .q     (plane[k])
        );
    end

    for (genvar j = 0; j < NUM_DISP; j++) begin : g_disp
        for (genvar k = 0; k < DIGIT_W; k++) begin : g_bit
            assign digit[j][k] = plane[k][j];
        end
        seg_decoder u_dec (
            .code  (digit[j]),
            .seg_n (seg[j])
        );
    end

    assign seg_disp0 = seg[0];
    assign seg_disp1 = seg[1];
    assign seg_disp2 = seg[2];
    assign seg_disp3 = seg[3];

    // R3: a step carries the last display's digit into display 0
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> (digit[0] == $past(digit[NUM_DISP-1])));
    // R3: a step carries display 0's digit into display 1
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> (digit[1] == $past(digit[0])));
endmodule

// File: tb/sim_digit_ticker.sv
module sim_digit_ticker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_sw = 1'b0;
    logic [6:0] s0, s1, s2, s3;
    logic [6:0] x [4][4];

    int total = 0;
    int bad = 0;
    int exp_d [4];
    int done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    digit_ticker u0 (.clk(clk), .rst_n(rst_n), .step_sw(step_sw),
        .seg_disp0(s0), .seg_disp1(s1), .seg_disp2(s2), .seg_disp3(s3));

    digit_ticker #(.DATE_BCD(16'h1456)) u1 (.clk(clk), .rst_n(rst_n), .step_sw(step_sw),
        .seg_disp0(x[0][0]), .seg_disp1(x[0][1]), .seg_disp2(x[0][2]), .seg_disp3(x[0][3]));
    digit_ticker #(.DATE_BCD(16'h789A)) u2 (.clk(clk), .rst_n(rst_n), .step_sw(step_sw),
        .seg_disp0(x[1][0]), .seg_disp1(x[1][1]), .seg_disp2(x[1][2]), .seg_disp3(x[1][3]));
    digit_ticker #(.DATE_BCD(16'hBCDE)) u3 (.clk(clk), .rst_n(rst_n), .step_sw(step_sw),
        .seg_disp0(x[2][0]), .seg_disp1(x[2][1]), .seg_disp2(x[2][2]), .seg_disp3(x[2][3]));
    digit_ticker #(.DATE_BCD(16'hF000)) u4 (.clk(clk), .rst_n(rst_n), .step_sw(step_sw),
        .seg_disp0(x[3][0]), .seg_disp1(x[3][1]), .seg_disp2(x[3][2]), .seg_disp3(x[3][3]));

    // Expected active-low gfedcba pattern for a code (R2).
    function automatic logic [6:0] seg_of(input int c);
        logic [6:0] on;
        case (c)
            0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
            4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
            8: on = 7'h7F;  9: on = 7'h6F;  10: on = 7'h77; 11: on = 7'h7C;
            12: on = 7'h39; 13: on = 7'h5E; 14: on = 7'h79; default: on = 7'h71;
        endcase
        return ~on;
    endfunction

    task automatic check_seg(input string req, input logic [6:0] act, input logic [6:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic check_u0(input string req);
        check_seg(req, s0, seg_of(exp_d[0]));
        check_seg(req, s1, seg_of(exp_d[1]));
        check_seg(req, s2, seg_of(exp_d[2]));
        check_seg(req, s3, seg_of(exp_d[3]));
    endtask

    task automatic model_step();
        int last = exp_d[3];
        exp_d[3] = exp_d[2];
        exp_d[2] = exp_d[1];
        exp_d[1] = exp_d[0];
        exp_d[0] = last;
    endtask

    task automatic model_reset();
        exp_d[0] = 0; exp_d[1] = 3; exp_d[2] = 2; exp_d[3] = 3;
    endtask

    // Full switch press: high long enough to step, then low long enough to settle.
    task automatic press();
        @(negedge clk) step_sw = 1'b1;
        repeat (5) @(negedge clk);
        step_sw = 1'b0;
        repeat (5) @(negedge clk);
        model_step();
    endtask

    // Reset state of u0 and of every extra instance (R1, R2).
    task automatic t_reset_state();
        int dates [4] = '{'h1456, 'h789A, 'hBCDE, 'hF000};
        model_reset();
        check_u0("R1 reset digits 0,3,2,3");
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                check_seg("R2 decode all codes", x[i][j], seg_of((dates[i] >> ((3-j)*4)) & 15));
    endtask

    // Step latency, single step on held switch, no step on fall (R5, R6, R3).
    task automatic t_latency_hold();
        @(negedge clk) step_sw = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_u0("R5 no change before third edge");
        @(posedge clk);
        @(negedge clk);
        model_step();
        check_u0("R5 change on third edge / R3 one step");
        repeat (8) @(negedge clk);
        check_u0("R6 held switch gives one step");
        step_sw = 1'b0;
        repeat (6) @(negedge clk);
        check_u0("R6 falling edge gives no step");
    endtask

    // Idle hold (R7).
    task automatic t_idle();
        repeat (20) @(negedge clk);
        check_u0("R7 idle hold");
    endtask

    // Remaining steps and wrap-around (R3, R4).
    task automatic t_full_cycle();
        press();
        check_u0("R3 second step");
        press();
        check_u0("R3 third step");
        press();
        check_u0("R4 back to reset after four steps");
        model_reset();
        check_u0("R4 matches reset digits");
    endtask

    // Reset after one step reloads the date (R8).
    task automatic t_mid_reset();
        press();
        check_u0("R3 step before reset");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        model_reset();
        check_u0("R8 reload at reset edge");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_u0("R8 holds date after release");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (done == 0) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_latency_hold();
        t_idle();
        t_full_cycle();
        t_mid_reset();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule